// File: doc/BRIEF.md
# Supervisor Configuration Register with Serial Write Path

This block is a one-byte control register that sits behind the write side of an I2C target. It sits inside a supply-supervisor die. A bus master selects it with a fixed 7-bit device address and the write direction bit, then sends a register-select byte that must be all ones. After that the master may send one data byte. The block acknowledges that byte, latches it, and refuses every byte after it. Two fields of that byte are persistent: a two-bit lock code and a two-bit power-on delay select. They are written into modelled persistent cells only when the master ends the transfer with a STOP, and only while the write-protect input is low. Each such store raises a one-cycle commit pulse, followed by a busy window of a parameterised length. While busy, the block refuses its device address.

The block also holds volatile monitor flags, one per external fail input. A data byte can set a flag only while its fail input is high. A flag drops as soon as its fail input goes low. The lock code gates a separate wiper-write strobe: the strobe passes only with lock code 00 and write-protect low. The delay select is also brought out as a cycle count. Bus lines are resynchronised to the system clock. START and STOP conditions are recognised from SDA edges while SCL is high.

Data byte layout: bits [1:0] are the lock code, bits [3:2] are the delay select, and bit 4+i sets monitor flag i. Bits 7:6 are don't-care.

Top module: `supv_cfg_reg`

## Requirements
- R1: A first byte of 8'hA4 (device address 7'b1010010 with direction bit 0) is acknowledged. Any other first byte, including 8'hA5, is not acknowledged, and the rest of that transfer has no effect.
- R2: The second byte must be 8'hFF. Any other value is not acknowledged, and the transfer then commits nothing.
- R3: The first data byte is acknowledged. Every further data byte in the same transfer is not acknowledged and is ignored.
- R4: A STOP that follows an accepted data byte raises commit_o for one cycle. lock_o then takes data bits [1:0] and dly_sel_o takes data bits [3:2]. A transfer that ends without a STOP (a repeated START) commits nothing.
- R5: wiper_we_o follows wiper_we_i only while lock_o is 2'b00 and wp_i is low. Otherwise it is 0.
- R6: dly_cyc_o equals CYC_PER_MS times 50, 100, 200 or 300 for dly_sel_o 0, 1, 2 or 3.
- R7: nv_blank_n low loads lock 2'b00 and delay select 2'b01. rst_n leaves both persistent fields unchanged.
- R8: Monitor flags are 0 after rst_n. An accepted data byte sets flag i only if data bit 4+i is 1 and fail_i[i] is high.
- R9: A flag whose fail_i input is low reads 0 from the next cycle onwards.
- R10: While wp_i is high, a STOP commits nothing and leaves both persistent fields unchanged, whatever the lock code.
- R11: After a commit, busy_o is high for exactly BUSY_CYC cycles. A device address byte that ends while busy_o is high is not acknowledged.
- R12: A START in the middle of a byte discards any accepted but uncommitted data. The new transfer starts from its device address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-cycle reset for the bus logic, flags and busy timer |
| nv_blank_n | input | 1 | Active-low load of the factory values into the persistent cells |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe_o | output | 1 | Pull SDA low (acknowledge) |
| wp_i | input | 1 | Write protect, active high |
| fail_i | input | NMON | Monitor fail inputs |
| wiper_we_i | input | 1 | Requested wiper write strobe |
| wiper_we_o | output | 1 | Permitted wiper write strobe |
| commit_o | output | 1 | One-cycle persistent store pulse |
| busy_o | output | 1 | Store in progress |
| lock_o | output | 2 | Committed lock code |
| dly_sel_o | output | 2 | Committed power-on delay select |
| mon_flag_o | output | NMON | Volatile monitor flags |
| dly_cyc_o | output | DW | Power-on delay in clock cycles |

## Verification
Bus lines pass through two synchroniser flops and one edge flop, so any bus event reaches the logic about three cycles after the pin changes. The bench therefore holds every SCL phase for eight cycles and samples the acknowledge in the middle of the ninth clock's high phase. Commits, field values, the delay count and the wiper gate are checked only after the STOP phase has fully elapsed and busy_o has dropped. The busy length is measured by a counter running every cycle. Flag clearing is checked three cycles after fail_i falls, although the requirement needs only one.

// File: rtl/supv_cfg_pkg.sv
package supv_cfg_pkg;

  localparam logic [6:0] DEV_ADDR = 7'b1010010;
  localparam logic [7:0] REG_SEL  = 8'hFF;
  localparam logic [1:0] LOCK_DEF = 2'b00;
  localparam logic [1:0] DSEL_DEF = 2'b01;
  localparam int unsigned FLD_W   = 6;  // bits of the data byte that carry fields

  typedef enum logic [2:0] {
    S_IDLE, S_DEV, S_REG, S_DAT, S_IGN
  } rx_st_t;

  // nominal power-on delay in milliseconds per select code
  function automatic int unsigned dly_ms(input logic [1:0] sel);
    case (sel)
      2'd0:    return 50;
      2'd1:    return 100;
      2'd2:    return 200;
      default: return 300;
    endcase
  endfunction

  function automatic int unsigned dly_cycles(input logic [1:0] sel, input int unsigned cpm);
    return dly_ms(sel) * cpm;
  endfunction

endpackage

// File: rtl/cfg_line_sync.sv
module cfg_line_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic start_ev,
  output logic stop_ev,
  output logic rise_ev,
  output logic fall_ev
);
  logic scl_m, scl_s, scl_p;
  logic sda_m, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_m <= 1'b1; scl_s <= 1'b1; scl_p <= 1'b1;
      sda_m <= 1'b1; sda_s <= 1'b1; sda_p <= 1'b1;
    end else begin
      scl_m <= scl_i; scl_s <= scl_m; scl_p <= scl_s;
      sda_m <= sda_i; sda_s <= sda_m; sda_p <= sda_s;
    end
  end

  assign start_ev = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_ev  = scl_s & scl_p & ~sda_p & sda_s;
  assign rise_ev  = scl_s & ~scl_p;
  assign fall_ev  = ~scl_s & scl_p;
endmodule

// File: rtl/cfg_byte_rx.sv
module cfg_byte_rx
  import supv_cfg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sda_s,
  input  logic             start_ev,
  input  logic             stop_ev,
  input  logic             rise_ev,
  input  logic             fall_ev,
  input  logic             busy_i,
  output logic             sda_oe_o,
  output logic             dat_stb_o,
  output logic [FLD_W-1:0] dat_o,
  output logic             commit_req_o
);
  rx_st_t     st;
  logic [3:0] cnt;
  logic [7:0] sh;
  logic       ackp, have;
  logic [7:0] nb;
  logic       last_bit;

  assign nb           = {sh[6:0], sda_s};
  assign last_bit     = rise_ev && (st != S_IDLE) && (cnt == 4'd7);
  assign dat_stb_o    = last_bit && (st == S_DAT);
  assign dat_o        = nb[FLD_W-1:0];
  assign commit_req_o = stop_ev && have;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; sh <= '0;
      ackp <= 1'b0; have <= 1'b0; sda_oe_o <= 1'b0;
    end else if (start_ev) begin
      st <= S_DEV; cnt <= '0; ackp <= 1'b0; have <= 1'b0; sda_oe_o <= 1'b0;
    end else if (stop_ev) begin
      st <= S_IDLE; cnt <= '0; ackp <= 1'b0; have <= 1'b0; sda_oe_o <= 1'b0;
    end else if (st != S_IDLE) begin
      if (rise_ev && cnt < 4'd8) begin
        sh  <= nb;
        cnt <= cnt + 4'd1;
        if (cnt == 4'd7) begin
          case (st)
            S_DEV: begin
              ackp <= (nb == {DEV_ADDR, 1'b0}) && !busy_i;
              st   <= ((nb == {DEV_ADDR, 1'b0}) && !busy_i) ? S_REG : S_IGN;
            end
            S_REG: begin
              ackp <= (nb == REG_SEL);
              st   <= (nb == REG_SEL) ? S_DAT : S_IGN;
            end
            S_DAT: begin
              ackp <= 1'b1; have <= 1'b1; st <= S_IGN;
            end
            default: ackp <= 1'b0;
          endcase
        end
      end else if (fall_ev && cnt == 4'd8) begin
        sda_oe_o <= ackp;
        cnt      <= 4'd9;
      end else if (fall_ev && cnt == 4'd9) begin
        sda_oe_o <= 1'b0;
        cnt      <= '0;
        ackp     <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/cfg_field_store.sv
module cfg_field_store
  import supv_cfg_pkg::*;
#(
  parameter int unsigned NMON       = 2,
  parameter int unsigned BUSY_CYC   = 64,
  parameter int unsigned CYC_PER_MS = 1000,
  parameter int unsigned DW         = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             nv_blank_n,
  input  logic             wp_i,
  input  logic [NMON-1:0]  fail_i,
  input  logic             dat_stb,
  input  logic [FLD_W-1:0] dat,
  input  logic             commit_req,
  input  logic             wiper_we_i,
  output logic             commit_o,
  output logic             busy_o,
  output logic [1:0]       lock_o,
  output logic [1:0]       dly_sel_o,
  output logic [NMON-1:0]  flag_o,
  output logic             wiper_we_o,
  output logic [DW-1:0]    dly_cyc_o
);
  localparam int unsigned BW = $clog2(BUSY_CYC + 1);

  logic [3:0]      shadow;
  logic [BW-1:0]   bcnt;
  logic [NMON-1:0] set_req;

  assign commit_o   = commit_req && !wp_i;
  assign busy_o     = (bcnt != '0);
  assign wiper_we_o = wiper_we_i && !wp_i && (lock_o == 2'b00);
  assign dly_cyc_o  = DW'(dly_cycles(dly_sel_o, CYC_PER_MS));
  assign set_req    = dat_stb ? dat[4 +: NMON] : '0;

  // persistent cells: only the factory load or a commit changes them
  always_ff @(posedge clk or negedge nv_blank_n) begin
    if (!nv_blank_n) begin
      lock_o    <= LOCK_DEF;
      dly_sel_o <= DSEL_DEF;
    end else if (commit_o) begin
      lock_o    <= shadow[1:0];
      dly_sel_o <= shadow[3:2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow <= '0;
      bcnt   <= '0;
      flag_o <= '0;
    end else begin
      if (dat_stb) shadow <= dat[3:0];
      if (commit_o)     bcnt <= BW'(BUSY_CYC);
      else if (busy_o)  bcnt <= bcnt - 1'b1;
      flag_o <= fail_i & (flag_o | set_req);
    end
  end
endmodule

// File: rtl/supv_cfg_reg.sv
module supv_cfg_reg
  import supv_cfg_pkg::*;
#(
  parameter int unsigned NMON       = 2,
  parameter int unsigned BUSY_CYC   = 64,
  parameter int unsigned CYC_PER_MS = 1000,
  parameter int unsigned DW         = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            nv_blank_n,
  input  logic            scl_i,
  input  logic            sda_i,
  output logic            sda_oe_o,
  input  logic            wp_i,
  input  logic [NMON-1:0] fail_i,
  input  logic            wiper_we_i,
  output logic            wiper_we_o,
  output logic            commit_o,
  output logic            busy_o,
  output logic [1:0]      lock_o,
  output logic [1:0]      dly_sel_o,
  output logic [NMON-1:0] mon_flag_o,
  output logic [DW-1:0]   dly_cyc_o
);
  // named internal events, also watched by the checker
  logic             sda_s, start_ev, stop_ev, scl_rise_ev, scl_fall_ev;
  logic             dat_stb, commit_req;
  logic [FLD_W-1:0] dat;

  cfg_line_sync u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .start_ev(start_ev), .stop_ev(stop_ev),
    .rise_ev(scl_rise_ev), .fall_ev(scl_fall_ev)
  );

  cfg_byte_rx u_rx (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s),
    .start_ev(start_ev), .stop_ev(stop_ev),
    .rise_ev(scl_rise_ev), .fall_ev(scl_fall_ev),
    .busy_i(busy_o), .sda_oe_o(sda_oe_o),
    .dat_stb_o(dat_stb), .dat_o(dat), .commit_req_o(commit_req)
  );

  cfg_field_store #(
    .NMON(NMON), .BUSY_CYC(BUSY_CYC), .CYC_PER_MS(CYC_PER_MS), .DW(DW)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .nv_blank_n(nv_blank_n), .wp_i(wp_i),
    .fail_i(fail_i), .dat_stb(dat_stb), .dat(dat), .commit_req(commit_req),
    .wiper_we_i(wiper_we_i), .commit_o(commit_o), .busy_o(busy_o),
    .lock_o(lock_o), .dly_sel_o(dly_sel_o), .flag_o(mon_flag_o),
    .wiper_we_o(wiper_we_o), .dly_cyc_o(dly_cyc_o)
  );
endmodule

// File: rtl/supv_cfg_chk.sv
module supv_cfg_chk #(
  parameter int unsigned NMON = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            nv_blank_n,
  input logic            wp_i,
  input logic [NMON-1:0] fail_i,
  input logic            wiper_we_o,
  input logic            commit_o,
  input logic            busy_o,
  input logic [1:0]      lock_o,
  input logic [1:0]      dly_sel_o,
  input logic [NMON-1:0] mon_flag_o,
  input logic            sda_oe_o,
  input logic            stop_ev,
  input logic            scl_fall_ev
);
  p_lock_blocks_wiper_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((lock_o != 2'b00) || wp_i) |-> !wiper_we_o);

  p_nv_stable_r4: assert property (@(posedge clk) disable iff (!rst_n || !nv_blank_n)
    !commit_o |=> ($stable(lock_o) && $stable(dly_sel_o)));

  p_commit_on_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |-> stop_ev);

  p_wp_blocks_commit_r10: assert property (@(posedge clk) disable iff (!rst_n || !nv_blank_n)
    (stop_ev && wp_i) |=> ($stable(lock_o) && $stable(dly_sel_o)));

  p_busy_follows_commit_r11: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |=> busy_o);

  p_busy_source_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(commit_o));

  p_ack_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe_o) |-> $past(scl_fall_ev));

  for (genvar i = 0; i < NMON; i++) begin : g_flag
    p_flag_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !fail_i[i] |=> !mon_flag_o[i]);
    p_flag_needs_fail_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mon_flag_o[i]) |-> $past(fail_i[i]));
  end
endmodule

bind supv_cfg_reg supv_cfg_chk #(.NMON(NMON)) u_chk (
  .clk(clk), .rst_n(rst_n), .nv_blank_n(nv_blank_n), .wp_i(wp_i),
  .fail_i(fail_i), .wiper_we_o(wiper_we_o), .commit_o(commit_o),
  .busy_o(busy_o), .lock_o(lock_o), .dly_sel_o(dly_sel_o),
  .mon_flag_o(mon_flag_o), .sda_oe_o(sda_oe_o), .stop_ev(stop_ev),
  .scl_fall_ev(scl_fall_ev)
);

// File: tb/tb_supv_cfg_reg.sv
module tb_supv_cfg_reg;
  localparam int NMON = 2;
  localparam int BUSY = 400;
  localparam int CPM  = 3;
  localparam int DW   = 32;
  localparam int T    = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0, nv_blank_n = 1'b0;
  logic scl = 1'b1, sdad = 1'b1;
  logic wp = 1'b0, wiper_in = 1'b0;
  logic [NMON-1:0] fail = '0;
  logic sda_oe, wiper_out, commit, busy;
  logic [1:0] lock, dsel;
  logic [NMON-1:0] flags;
  logic [DW-1:0] dcyc;
  wire sda_line = sdad & ~sda_oe;

  int ntot = 0, nbad = 0, commits = 0, blen = 0, last_blen = 0;
  bit done = 0;

  always #10 clk = ~clk;

  supv_cfg_reg #(.NMON(NMON), .BUSY_CYC(BUSY), .CYC_PER_MS(CPM), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .nv_blank_n(nv_blank_n), .scl_i(scl), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .wp_i(wp), .fail_i(fail), .wiper_we_i(wiper_in),
    .wiper_we_o(wiper_out), .commit_o(commit), .busy_o(busy), .lock_o(lock),
    .dly_sel_o(dsel), .mon_flag_o(flags), .dly_cyc_o(dcyc)
  );

  always @(posedge clk) begin
    if (commit) commits <= commits + 1;
    if (busy) blen <= blen + 1;
    else if (blen != 0) begin last_blen <= blen; blen <= 0; end
  end

  task automatic tick(input int n); repeat (n) @(negedge clk); endtask

  task automatic check(input string tag, input longint act, input longint exp);
    ntot++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic i2c_start;
    sdad = 1'b1; tick(T); scl = 1'b1; tick(T); sdad = 1'b0; tick(T); scl = 1'b0; tick(T);
  endtask

  task automatic i2c_stop;
    sdad = 1'b0; tick(T); scl = 1'b1; tick(T); sdad = 1'b1; tick(T);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sdad = b[i]; tick(T); scl = 1'b1; tick(T); scl = 1'b0; tick(T);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ak);
    send_bits(b, 8);
    sdad = 1'b1; tick(T); scl = 1'b1; tick(T / 2);
    ak = sda_oe; tick(T / 2); scl = 1'b0; tick(T);
  endtask

  task automatic xfer(input logic [7:0] dv, input logic [7:0] rg, input logic [7:0] d0,
                      input logic [7:0] d1, input logic [7:0] d2, input int nd,
                      input bit stp, output logic [4:0] ak);
    logic a;
    ak = '0;
    i2c_start;
    send_byte(dv, a); ak[0] = a;
    send_byte(rg, a); ak[1] = a;
    if (nd > 0) begin send_byte(d0, a); ak[2] = a; end
    if (nd > 1) begin send_byte(d1, a); ak[3] = a; end
    if (nd > 2) begin send_byte(d2, a); ak[4] = a; end
    if (stp) i2c_stop;
  endtask

  task automatic wait_idle;
    tick(4);
    while (busy) tick(1);
    tick(4);
  endtask

  function automatic int exp_cyc(input logic [1:0] s);
    return ((s == 2'd0) ? 50 : 100 * int'(s)) * CPM;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      ntot++; nbad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", ntot, nbad);
      $finish;
    end
  end

  initial begin
    logic [4:0] ak;
    int c0;
    tick(5); rst_n = 1'b1; nv_blank_n = 1'b1; tick(5);

    // reset state
    check("R7 lock default", lock, 0);
    check("R7 dsel default", dsel, 1);
    check("R8 flags after reset", flags, 0);
    check("R11 busy idle", busy, 0);
    check("R3 sda idle", sda_oe, 0);
    check("R6 delay default", dcyc, exp_cyc(2'd1));

    // sweep all field codes
    wiper_in = 1'b1;
    for (int v = 0; v < 16; v++) begin
      c0 = commits;
      xfer(8'hA4, 8'hFF, 8'(v), 8'h00, 8'h00, 1, 1'b1, ak);
      wait_idle;
      check("R1 R2 R3 ack pattern", ak[2:0], 3'b111);
      check("R4 one commit", commits - c0, 1);
      check("R4 lock", lock, v & 3);
      check("R4 dsel", dsel, (v >> 2) & 3);
      check("R6 delay cycles", dcyc, exp_cyc(2'(v >> 2)));
      check("R5 wiper gate", wiper_out, ((v & 3) == 0) ? 1 : 0);
    end

    // R7: power-cycle keeps persistent fields, blank restores defaults
    rst_n = 1'b0; tick(3); rst_n = 1'b1; tick(3);
    check("R7 lock kept", lock, 3);
    check("R7 dsel kept", dsel, 3);
    nv_blank_n = 1'b0; tick(2); nv_blank_n = 1'b1; tick(2);
    check("R7 lock blank", lock, 0);
    check("R7 dsel blank", dsel, 1);

    // R1: wrong direction / wrong address
    c0 = commits;
    xfer(8'hA5, 8'hFF, 8'h0F, 8'h00, 8'h00, 1, 1'b1, ak); wait_idle;
    check("R1 read bit nack", ak[2:0], 3'b000);
    xfer(8'hA6, 8'hFF, 8'h0F, 8'h00, 8'h00, 1, 1'b1, ak); wait_idle;
    check("R1 other addr nack", ak[2:0], 3'b000);
    check("R1 no commit", commits - c0, 0);
    check("R1 lock unchanged", lock, 0);

    // R2: wrong register select
    xfer(8'hA4, 8'hFE, 8'h0F, 8'h00, 8'h00, 1, 1'b1, ak); wait_idle;
    check("R2 ack pattern", ak[2:0], 3'b001);
    check("R2 no commit", commits - c0, 0);
    check("R2 dsel unchanged", dsel, 1);

    // R3: extra data bytes refused and ignored
    xfer(8'hA4, 8'hFF, 8'h05, 8'h0A, 8'h0F, 3, 1'b1, ak); wait_idle;
    check("R3 ack pattern", ak, 5'b00111);
    check("R3 lock first byte", lock, 1);
    check("R3 dsel first byte", dsel, 1);

    // R10: write protect
    xfer(8'hA4, 8'hFF, 8'h04, 8'h00, 8'h00, 1, 1'b1, ak); wait_idle;
    wp = 1'b1; tick(2);
    check("R10 R5 wiper blocked by wp", wiper_out, 0);
    c0 = commits;
    xfer(8'hA4, 8'hFF, 8'h0B, 8'h00, 8'h00, 1, 1'b1, ak); tick(10);
    check("R10 no commit", commits - c0, 0);
    check("R10 busy low", busy, 0);
    check("R10 lock kept", lock, 0);
    check("R10 dsel kept", dsel, 1);
    wp = 1'b0; tick(2);

    // R4: repeated START instead of STOP
    c0 = commits;
    xfer(8'hA4, 8'hFF, 8'h0B, 8'h00, 8'h00, 1, 1'b0, ak);
    i2c_start; i2c_stop; wait_idle;
    check("R4 no stop no commit", commits - c0, 0);
    check("R4 lock after abort", lock, 0);

    // R12: START mid-byte, then a fresh transfer
    xfer(8'hA4, 8'hFF, 8'h0B, 8'h00, 8'h00, 1, 1'b0, ak);
    send_bits(8'hF0, 4);
    sdad = 1'b1; tick(T); scl = 1'b1; tick(T); sdad = 1'b0; tick(T); scl = 1'b0; tick(T);
    i2c_stop; wait_idle;
    check("R12 mid-byte start no commit", commits - c0, 0);
    xfer(8'hA4, 8'hFF, 8'h06, 8'h00, 8'h00, 1, 1'b1, ak); wait_idle;
    check("R12 restart acks", ak[2:0], 3'b111);
    check("R12 lock", lock, 2);

    // R11: busy length and address NACK while busy
    c0 = commits;
    xfer(8'hA4, 8'hFF, 8'h00, 8'h00, 8'h00, 1, 1'b1, ak);
    check("R11 busy after commit", busy, 1);
    xfer(8'hA4, 8'hFF, 8'h0F, 8'h00, 8'h00, 1, 1'b1, ak);
    check("R11 nack while busy", ak[2:0], 3'b000);
    wait_idle;
    check("R11 busy length", last_blen, BUSY);
    check("R11 single commit", commits - c0, 1);
    check("R11 lock", lock, 0);
    xfer(8'hA4, 8'hFF, 8'h04, 8'h00, 8'h00, 1, 1'b1, ak); wait_idle;
    check("R11 ack after busy", ak[2:0], 3'b111);

    // R8: flag set only with fail high (wp high keeps the store quiet)
    wp = 1'b1;
    for (int f = 0; f < 4; f++) begin
      for (int s = 0; s < 4; s++) begin
        fail = '0; tick(3); fail = 2'(f); tick(2);
        xfer(8'hA4, 8'hFF, 8'(s << 4), 8'h00, 8'h00, 1, 1'b1, ak); tick(4);
        check("R8 flag set", flags, f & s);
      end
    end

    // R9: clear on fail low
    fail = 2'b11; tick(2);
    xfer(8'hA4, 8'hFF, 8'h30, 8'h00, 8'h00, 1, 1'b1, ak); tick(4);
    check("R9 both set", flags, 3);
    fail = 2'b10; tick(3);
    check("R9 flag0 cleared", flags, 2);
    fail = 2'b00; tick(3);
    check("R9 flag1 cleared", flags, 0);

    // R8: power cycle clears flags
    fail = 2'b11; tick(2);
    xfer(8'hA4, 8'hFF, 8'h30, 8'h00, 8'h00, 1, 1'b1, ak); tick(4);
    rst_n = 1'b0; tick(3); rst_n = 1'b1; tick(3);
    check("R8 flags cleared by reset", flags, 0);
    wp = 1'b0;

    done = 1;
    $display("test done: total=%0d bad=%0d", ntot, nbad);
    $finish;
  end
endmodule